// File: doc/BRIEF.md
# Register Bank Datapath with Hardwired Zero Register

This block is the register storage of a small 32-bit load/store processor. It holds a bank of general-purpose registers with two combinational read ports and one clocked write port. The first read port is addressed directly by the `ra` instruction field. The second read port is addressed by either `rb` or `rc`, chosen by a select input. The write port is addressed by either `rc` or the fixed exception-pointer register, chosen by a second select input.

The highest-numbered register is not storage. It always reads as zero, and writes aimed at it are dropped. The block also produces a zero flag from the first read port for branch decisions. The second read word is forwarded unchanged as the data to be stored to memory.

Writes take effect only on a rising clock edge on which both the write enable and the step enable are high. The step enable lets a slower instruction cadence drive a fast clock. The active-low asynchronous reset clears every register.

Top module: `reg_bank_dp`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no write since, every register reads as 0 on both ports.
- R2: When `we_i`=1 and `step_en_i`=1 at a rising edge, `wdata_i` is stored in the selected write register. The read ports are combinational, so a read of that register returns the old value until the edge and the new value after it.
- R3: If `we_i`=0 or `step_en_i`=0 at a rising edge, no register changes.
- R4: Register 31 (address 5'b11111) reads as 0 on both read ports. A write addressed to it leaves every register unchanged.
- R5: The read port 2 address is `rb_i` when `rd2_sel_i`=0 and `rc_i` when `rd2_sel_i`=1.
- R6: The write address is `rc_i` when `wa_sel_i`=0. When `wa_sel_i`=1 it is register 30 (5'b11110), and register `rc_i` is left untouched.
- R7: `zero_o` is 1 when `rd1_o` is 32'h0000_0000 and 0 for any other value.
- R8: `mem_wdata_o` always equals `rd2_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ra_i | input | 5 | Read port 1 register address |
| rb_i | input | 5 | Read port 2 address candidate |
| rc_i | input | 5 | Destination register field; also a read port 2 address candidate |
| rd2_sel_i | input | 1 | 0: read port 2 uses rb_i, 1: uses rc_i |
| wa_sel_i | input | 1 | 0: write to rc_i, 1: write to register 30 |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write enable |
| step_en_i | input | 1 | Step enable qualifying writes |
| rd1_o | output | 32 | Read port 1 data |
| rd2_o | output | 32 | Read port 2 data |
| zero_o | output | 1 | High when rd1_o is zero |
| mem_wdata_o | output | 32 | Store data to memory (read port 2) |

## Verification
The bench builds the block with its defaults: 32-bit data and 32 registers. With these values the hardwired zero register sits at index 31 and the exception pointer at index 30, so the fixed index values called out in R4 and R6 are directly exercised. The bench sweeps all 32 read addresses after reset. It covers writes gated off by each enable alone, redirection of a write to register 30, and zero-flag transitions both from a stored zero and from a nonzero value. A reset asserted mid-run is also checked.

// File: rtl/reg_bank_pkg.sv
package reg_bank_pkg;
  typedef enum logic {
    RD2_FROM_RB = 1'b0,
    RD2_FROM_RC = 1'b1
  } rd2_src_e;

  typedef enum logic {
    WA_FROM_RC = 1'b0,
    WA_TO_XP   = 1'b1
  } wa_src_e;
endpackage

// File: rtl/rb_addr_sel.sv
module rb_addr_sel #(
  parameter int ADDR_W = 5,
  parameter int XP_IDX = 30
) (
  input  logic [ADDR_W-1:0] rb_i,
  input  logic [ADDR_W-1:0] rc_i,
  input  logic              rd2_sel_i,
  input  logic              wa_sel_i,
  output logic [ADDR_W-1:0] rd2_addr_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  import reg_bank_pkg::*;

  rd2_src_e rd2_src;
  wa_src_e  wa_src;

  assign rd2_src = rd2_src_e'(rd2_sel_i);
  assign wa_src  = wa_src_e'(wa_sel_i);

  always_comb begin
    unique case (rd2_src)
      RD2_FROM_RC: rd2_addr_o = rc_i;
      default:     rd2_addr_o = rb_i;
    endcase
  end

  always_comb begin
    unique case (wa_src)
      WA_TO_XP: wr_addr_o = ADDR_W'(XP_IDX);
      default:  wr_addr_o = rc_i;
    endcase
  end
endmodule

// File: rtl/rb_storage.sv
module rb_storage #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS),
  localparam int NUM_PHY = NUM_REGS - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd1_addr_i,
  input  logic [ADDR_W-1:0] rd2_addr_i,
  output logic [DATA_W-1:0] rd1_data_o,
  output logic [DATA_W-1:0] rd2_data_o
);
  logic [DATA_W-1:0] regs_view [NUM_REGS];
  logic [NUM_PHY-1:0] wr_hit;

  // Only NUM_REGS-1 physical registers; the top index has no storage.
  for (genvar i = 0; i < NUM_PHY; i++) begin : g_reg
    logic [DATA_W-1:0] q;

    assign wr_hit[i] = wr_en_i && (wr_addr_i == ADDR_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q <= '0;
      else if (wr_hit[i]) q <= wr_data_i;
    end

    assign regs_view[i] = q;
  end

  assign regs_view[NUM_PHY] = '0;

  assign rd1_data_o = regs_view[rd1_addr_i];
  assign rd2_data_o = regs_view[rd2_addr_i];
endmodule

// File: rtl/rb_zero_detect.sv
module rb_zero_detect #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              zero_o
);
  assign zero_o = ~|data_i;
endmodule

// File: rtl/reg_bank_dp.sv
module reg_bank_dp #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [$clog2(NUM_REGS)-1:0] ra_i,
  input  logic [$clog2(NUM_REGS)-1:0] rb_i,
  input  logic [$clog2(NUM_REGS)-1:0] rc_i,
  input  logic                        rd2_sel_i,
  input  logic                        wa_sel_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic                        we_i,
  input  logic                        step_en_i,
  output logic [DATA_W-1:0]           rd1_o,
  output logic [DATA_W-1:0]           rd2_o,
  output logic                        zero_o,
  output logic [DATA_W-1:0]           mem_wdata_o
);
  localparam int ADDR_W = $clog2(NUM_REGS);
  localparam int XP_IDX = NUM_REGS - 2;

  logic [ADDR_W-1:0] rd2_addr;
  logic [ADDR_W-1:0] wr_addr;
  logic              wr_en;

  assign wr_en = we_i & step_en_i;

  rb_addr_sel #(
    .ADDR_W (ADDR_W),
    .XP_IDX (XP_IDX)
  ) u_addr_sel (
    .rb_i       (rb_i),
    .rc_i       (rc_i),
    .rd2_sel_i  (rd2_sel_i),
    .wa_sel_i   (wa_sel_i),
    .rd2_addr_o (rd2_addr),
    .wr_addr_o  (wr_addr)
  );

  rb_storage #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_storage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wdata_i),
    .rd1_addr_i (ra_i),
    .rd2_addr_i (rd2_addr),
    .rd1_data_o (rd1_o),
    .rd2_data_o (rd2_o)
  );

  rb_zero_detect #(
    .DATA_W (DATA_W)
  ) u_zero (
    .data_i (rd1_o),
    .zero_o (zero_o)
  );

  assign mem_wdata_o = rd2_o;
endmodule

// File: rtl/reg_bank_dp_chk.sv
module reg_bank_dp_chk #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [$clog2(NUM_REGS)-1:0] ra_i,
  input logic [$clog2(NUM_REGS)-1:0] rb_i,
  input logic [$clog2(NUM_REGS)-1:0] rc_i,
  input logic                        rd2_sel_i,
  input logic                        wa_sel_i,
  input logic [DATA_W-1:0]           wdata_i,
  input logic                        we_i,
  input logic                        step_en_i,
  input logic [DATA_W-1:0]           rd1_o,
  input logic [DATA_W-1:0]           rd2_o,
  input logic                        zero_o
);
  localparam int ADDR_W = $clog2(NUM_REGS);
  localparam logic [ADDR_W-1:0] ZR = ADDR_W'(NUM_REGS - 1);
  localparam logic [ADDR_W-1:0] XP = ADDR_W'(NUM_REGS - 2);

  logic [ADDR_W-1:0] rd2_a;
  assign rd2_a = rd2_sel_i ? rc_i : rb_i;

  p_wr_visible_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && step_en_i && !wa_sel_i && rc_i != ZR)
    |=> (ra_i != $past(rc_i) || rd1_o == $past(wdata_i)));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && step_en_i) |=> (ra_i != $past(ra_i) || $stable(rd1_o)));

  p_zr_rd1_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_i == ZR) |-> (rd1_o == '0));

  p_zr_rd2_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd2_a == ZR) |-> (rd2_o == '0));

  p_xp_redirect_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && step_en_i && wa_sel_i)
    |=> (ra_i != XP || rd1_o == $past(wdata_i)));

  p_zero_after_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && step_en_i && !wa_sel_i && wdata_i == '0)
    |=> (ra_i != $past(rc_i) || zero_o));
endmodule

bind reg_bank_dp reg_bank_dp_chk #(
  .DATA_W   (DATA_W),
  .NUM_REGS (NUM_REGS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ra_i      (ra_i),
  .rb_i      (rb_i),
  .rc_i      (rc_i),
  .rd2_sel_i (rd2_sel_i),
  .wa_sel_i  (wa_sel_i),
  .wdata_i   (wdata_i),
  .we_i      (we_i),
  .step_en_i (step_en_i),
  .rd1_o     (rd1_o),
  .rd2_o     (rd2_o),
  .zero_o    (zero_o)
);

// File: tb/tb_reg_bank_dp.sv
module tb_reg_bank_dp;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NR = 32;
  localparam int AW = $clog2(NR);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] ra = '0, rb = '0, rc = '0;
  logic s2 = 1'b0, ws = 1'b0, we = 1'b0, en = 1'b0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rd1, rd2, mwd;
  logic zf;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [DW-1:0] rd1;
    logic [DW-1:0] rd2;
    logic          z;
    string         tag;
  } exp_t;

  exp_t sb_q[$];
  logic [DW-1:0] model [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_bank_dp #(.DATA_W(DW), .NUM_REGS(NR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ra_i(ra), .rb_i(rb), .rc_i(rc),
    .rd2_sel_i(s2), .wa_sel_i(ws), .wdata_i(wd), .we_i(we),
    .step_en_i(en), .rd1_o(rd1), .rd2_o(rd2), .zero_o(zf),
    .mem_wdata_o(mwd)
  );

  // Reference register contents, from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) model[i] = '0;
    end else if (we && en) begin
      int wa;
      wa = ws ? NR - 2 : int'(rc);
      if (wa != NR - 1) model[wa] = wd;
    end
  end

  function automatic logic [DW-1:0] rd_model(input int a);
    return (a == NR - 1) ? '0 : model[a];
  endfunction

  task automatic drive(input int a1, input int b, input int c, input bit sel2,
                       input bit wsel, input logic [DW-1:0] d, input bit w,
                       input bit e, input string tag);
    exp_t x;
    @(negedge clk);
    ra = AW'(a1); rb = AW'(b); rc = AW'(c);
    s2 = sel2; ws = wsel; wd = d; we = w; en = e;
    x.rd1 = rd_model(a1);
    x.rd2 = rd_model(sel2 ? c : b);
    x.z   = (x.rd1 == '0);
    x.tag = tag;
    sb_q.push_back(x);
  endtask

  // Monitor: compare a quarter period after each drive
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (sb_q.size() > 0) begin
        exp_t x;
        x = sb_q.pop_front();
        total++;
        if (rd1 !== x.rd1 || rd2 !== x.rd2 || zf !== x.z || mwd !== x.rd2) begin
          bad++;
          $display("FAIL %s: rd1=%h rd2=%h z=%b mwd=%h exp rd1=%h rd2=%h z=%b mwd=%h",
                   x.tag, rd1, rd2, zf, mwd, x.rd1, x.rd2, x.z, x.rd2);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete, exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reads during reset
    drive(0, 1, 2, 0, 0, 32'h0, 0, 0, "R1 in reset");
    drive(7, 30, 9, 0, 0, 32'h0, 1, 1, "R1 in reset, write blocked");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) drive(i, i + 16, 0, 0, 0, 32'h0, 0, 1, "R1 post reset sweep");

    // R2: write, old value in write cycle, new value after
    drive(5, 0, 5, 0, 0, 32'hDEAD_BEEF, 1, 1, "R2 write cycle shows old");
    drive(5, 5, 0, 0, 0, 32'h0, 0, 1, "R2 new value R8 mwd");

    // R3: each enable alone blocks the write
    drive(6, 0, 6, 0, 0, 32'h1111_1111, 1, 0, "R3 step_en low");
    drive(6, 7, 7, 0, 0, 32'h2222_2222, 0, 1, "R3 we low");
    drive(6, 7, 0, 0, 0, 32'h0, 0, 1, "R3 r6 r7 unchanged");

    // R4: register 31
    drive(31, 31, 31, 0, 0, 32'hCAFE_F00D, 1, 1, "R4 write to r31");
    drive(31, 0, 31, 1, 0, 32'h0, 0, 1, "R4 r31 reads zero both ports");
    drive(5, 0, 31, 1, 0, 32'h0, 0, 1, "R4 other regs untouched");

    // R5: read port 2 source select
    drive(0, 0, 8, 0, 0, 32'hAAAA_0001, 1, 1, "R5 load r8");
    drive(0, 0, 9, 0, 0, 32'hBBBB_0002, 1, 1, "R5 load r9");
    drive(0, 8, 9, 0, 0, 32'h0, 0, 1, "R5 sel rb");
    drive(0, 8, 9, 1, 0, 32'h0, 0, 1, "R5 sel rc");

    // R6: redirect to r30
    drive(30, 3, 3, 0, 1, 32'h1234_5678, 1, 1, "R6 redirect cycle");
    drive(30, 3, 0, 0, 0, 32'h0, 0, 1, "R6 r30 written r3 untouched");

    // R7: zero flag
    drive(0, 0, 10, 0, 0, 32'h0000_0001, 1, 1, "R7 r0 zero");
    drive(10, 0, 10, 0, 0, 32'h0, 1, 1, "R7 nonzero");
    drive(10, 0, 11, 0, 0, 32'h8000_0000, 1, 1, "R7 after zero write");
    drive(11, 10, 0, 0, 0, 32'h0, 0, 1, "R7 msb only nonzero");

    // R1: reset asserted mid-run
    @(negedge clk);
    rst_n = 1'b0;
    drive(5, 30, 9, 1, 0, 32'h0, 0, 1, "R1 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    drive(11, 8, 9, 0, 0, 32'h0, 0, 1, "R1 after mid-run reset");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule